// File: doc/BRIEF.md
# Dual-Bank Switch Connection Allocator

This block decides where each connection of a time-slot switch is placed when the switch is built from two identical connection banks. A command either makes or breaks a connection, naming a source stream and timeslot and a destination stream and timeslot. For a make, the block picks the first bank that can accept the connection, records it, and answers with success and the bank. If no bank can accept it, or the command is invalid, it answers with an error code. For a break, it finds the bank that holds the connection and frees it.

The low-numbered streams are bus streams, grouped in pairs (2k, 2k+1). Each bank keeps one direction bit for every (pair, timeslot). The bit says which stream of the pair acts as the switch input at that slot; the partner stream is then the output. While any connection in that bank uses the slot, the bit is held, and a per-slot reference count releases it when the last user goes away. Streams at or above the bus count are local and never take part in direction checks. Because the bit is kept per bank, a connection refused by the first bank can often still be placed in the second.

Commands are accepted in every cycle that `cmd_valid` is high. The answer for a command appears in the following cycle.

Top module: `dual_bank_conn_alloc`

## Requirements
- R1: After reset `rsp_valid` is low, every bank is empty and no destination is connected, so the first make that fits goes to bank 0.
- R2: A command sampled with `cmd_valid` high gives `rsp_valid` high exactly one cycle later, and only then. `rsp_ok`=1 means success, `rsp_bank` is the bank (0 or 1), and `rsp_err` encodes 0 none, 1 blocked, 2 destination busy, 3 not connected.
- R3: A bus stream s belongs to pair s/2. A source on an even stream, or a destination on an odd stream, needs the pair's slot set to "even is input". A source on an odd stream, or a destination on an even stream, needs "odd is input". A connection that agrees with a slot already set in a bank may share that slot in that bank.
- R4: Banks are tried in fixed order. A make goes to bank 0 when bank 0 can take it, and to bank 1 only when bank 0 cannot.
- R5: A slot's direction in a bank stays fixed while its reference count is non-zero. It becomes free only after every connection using it has been broken.
- R6: Each bank holds at most CAP (default 128) connections. When bank 0 is full, a make that fits bank 1 goes to bank 1. Breaking a bank-0 connection makes room there again.
- R7: A make that bank 0 cannot take (full or in conflict) and that conflicts with bank 1 fails with error 1 and changes nothing.
- R8: Local streams (index >= NBUS) carry no direction constraint. They are limited only by capacity.
- R9: A make whose destination already has a connection fails with error 2 and leaves the existing connection intact.
- R10: A break whose destination has no connection, or whose source differs from the recorded one, fails with error 3. A matching break succeeds, reports the holding bank and frees the destination.
- R11: A make whose source and destination fall on the same pair and slot but need opposite directions fails with error 1 in both banks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_break | input | 1 | 1 = break connection, 0 = make connection |
| cmd_src_stream | input | SW | Source stream number |
| cmd_src_slot | input | TW | Source timeslot |
| cmd_dst_stream | input | SW | Destination stream number |
| cmd_dst_slot | input | TW | Destination timeslot |
| rsp_valid | output | 1 | Result present (one cycle after command) |
| rsp_ok | output | 1 | Command succeeded |
| rsp_bank | output | 1 | Bank that holds or held the connection |
| rsp_err | output | 2 | 0 none, 1 blocked, 2 destination busy, 3 not connected |

## Verification
The hardest state to reach is a full bank 0 together with a direction already set in bank 1 that opposes a new request. The stimulus builds this in order. First it forces one bus connection into bank 1 by setting the opposite direction in bank 0. Next it fills the rest of bank 0 with local-to-local connections, which carry no direction. Then it issues both a conflicting and a matching request. Before the fill, the reference counts are exercised through fan-out from one source slot, and release is shown when a request that used to be pushed into bank 1 lands back in bank 0.

// File: rtl/xbar_alloc_pkg.sv
package xbar_alloc_pkg;
  typedef enum logic [1:0] {
    ERR_NONE     = 2'd0,
    ERR_BLOCKED  = 2'd1,
    ERR_DST_BUSY = 2'd2,
    ERR_NO_CONN  = 2'd3
  } alloc_err_e;
endpackage

// File: rtl/conn_bank.sv
// One connection bank: per (pair, slot) direction bit and reference count,
// plus the bank occupancy. Answers whether a request fits and applies updates.
module conn_bank #(
  parameter int NENT = 64,
  parameter int CAP  = 128,
  parameter int CW   = 10,
  parameter int EW   = $clog2(NENT),
  parameter int UW   = $clog2(CAP + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_use,
  input  logic [EW-1:0] src_ent,
  input  logic          src_need,
  input  logic          dst_use,
  input  logic [EW-1:0] dst_ent,
  input  logic          dst_need,
  input  logic          add_en,
  input  logic          rel_en,
  output logic          can_place
);
  logic [CW-1:0] cnt_q [NENT];
  logic [CW-1:0] cnt_d [NENT];
  logic          dir_q [NENT];
  logic          dir_d [NENT];
  logic [UW-1:0] used_q, used_d;
  logic          src_bad, dst_bad, pair_bad, full;

  always_comb begin
    src_bad  = src_use && (cnt_q[src_ent] != '0) && (dir_q[src_ent] != src_need);
    dst_bad  = dst_use && (cnt_q[dst_ent] != '0) && (dir_q[dst_ent] != dst_need);
    pair_bad = src_use && dst_use && (src_ent == dst_ent) && (src_need != dst_need);
    full     = (used_q >= UW'(CAP));
    can_place = !full && !src_bad && !dst_bad && !pair_bad;
  end

  always_comb begin
    for (int e = 0; e < NENT; e++) begin
      logic hs, hd;
      hs = src_use && (src_ent == EW'(e));
      hd = dst_use && (dst_ent == EW'(e));
      cnt_d[e] = cnt_q[e];
      dir_d[e] = dir_q[e];
      if (add_en) begin
        cnt_d[e] = cnt_q[e] + CW'(hs) + CW'(hd);
        if (cnt_q[e] == '0) begin
          if (hs)      dir_d[e] = src_need;
          else if (hd) dir_d[e] = dst_need;
        end
      end else if (rel_en) begin
        cnt_d[e] = cnt_q[e] - CW'(hs) - CW'(hd);
      end
    end
    used_d = used_q;
    if (add_en)      used_d = used_q + 1'b1;
    else if (rel_en) used_d = used_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
      for (int e = 0; e < NENT; e++) begin
        cnt_q[e] <= '0;
        dir_q[e] <= 1'b0;
      end
    end else if (add_en || rel_en) begin
      used_q <= used_d;
      for (int e = 0; e < NENT; e++) begin
        cnt_q[e] <= cnt_d[e];
        dir_q[e] <= dir_d[e];
      end
    end
  end

  AST_CAP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    used_q <= UW'(CAP)); // R6

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_en && src_use) |-> (cnt_q[src_ent] != '0)); // R10

  for (genvar g = 0; g < NENT; g++) begin : g_dir_chk
    AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q[g] != '0) |=> ((cnt_q[g] == '0) || $stable(dir_q[g]))); // R5
  end
endmodule

// File: rtl/dst_table.sv
// Per-destination record: connected flag, holding bank and source key.
module dst_table #(
  parameter int NDST = 512,
  parameter int SRCW = 9,
  parameter int DW   = $clog2(NDST)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   idx,
  output logic            rd_hit,
  output logic            rd_bank,
  output logic [SRCW-1:0] rd_src,
  input  logic            set_en,
  input  logic            set_bank,
  input  logic [SRCW-1:0] set_src,
  input  logic            clr_en
);
  logic            vld_q  [NDST];
  logic            bank_q [NDST];
  logic [SRCW-1:0] src_q  [NDST];

  assign rd_hit  = vld_q[idx];
  assign rd_bank = bank_q[idx];
  assign rd_src  = src_q[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < NDST; d++) begin
        vld_q[d]  <= 1'b0;
        bank_q[d] <= 1'b0;
        src_q[d]  <= '0;
      end
    end else if (set_en) begin
      vld_q[idx]  <= 1'b1;
      bank_q[idx] <= set_bank;
      src_q[idx]  <= set_src;
    end else if (clr_en) begin
      vld_q[idx] <= 1'b0;
    end
  end

  AST_SET_FREE_DST: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |-> !rd_hit); // R9

  AST_CLR_USED_DST: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |-> rd_hit); // R10
endmodule

// File: rtl/dual_bank_conn_alloc.sv
module dual_bank_conn_alloc
  import xbar_alloc_pkg::*;
#(
  parameter int NSTR  = 16,
  parameter int NBUS  = 4,
  parameter int NSLOT = 32,
  parameter int CAP   = 128,
  parameter int SW    = $clog2(NSTR),
  parameter int TW    = $clog2(NSLOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic          cmd_break,
  input  logic [SW-1:0] cmd_src_stream,
  input  logic [TW-1:0] cmd_src_slot,
  input  logic [SW-1:0] cmd_dst_stream,
  input  logic [TW-1:0] cmd_dst_slot,
  output logic          rsp_valid,
  output logic          rsp_ok,
  output logic          rsp_bank,
  output logic [1:0]    rsp_err
);
  localparam int NPAIR = NBUS / 2;
  localparam int NENT  = NPAIR * NSLOT;
  localparam int EW    = (NENT > 1) ? $clog2(NENT) : 1;
  localparam int NDST  = NSTR * NSLOT;
  localparam int DW    = $clog2(NDST);
  localparam int SRCW  = SW + TW;
  localparam int CW    = $clog2(NDST + 1) + 1;

  logic            src_bus, dst_bus, src_need, dst_need;
  logic [EW-1:0]   src_ent, dst_ent;
  logic [DW-1:0]   dst_idx;
  logic [SRCW-1:0] src_key;
  logic            mk, bk;
  logic [1:0]      can_b, add_b, rel_b;
  logic            dt_hit, dt_bank, set_en, clr_en;
  logic [SRCW-1:0] dt_src;
  logic            ok_d, bank_d;
  alloc_err_e      err_d;

  always_comb begin
    src_bus  = (int'(cmd_src_stream) < NBUS);
    dst_bus  = (int'(cmd_dst_stream) < NBUS);
    src_ent  = EW'(int'(cmd_src_stream >> 1) * NSLOT + int'(cmd_src_slot));
    dst_ent  = EW'(int'(cmd_dst_stream >> 1) * NSLOT + int'(cmd_dst_slot));
    // direction value 1: even stream of the pair is the switch input
    src_need = ~cmd_src_stream[0];
    dst_need = cmd_dst_stream[0];
    dst_idx  = DW'(int'(cmd_dst_stream) * NSLOT + int'(cmd_dst_slot));
    src_key  = {cmd_src_stream, cmd_src_slot};
    mk       = cmd_valid && !cmd_break;
    bk       = cmd_valid && cmd_break;
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    conn_bank #(.NENT(NENT), .CAP(CAP), .CW(CW), .EW(EW)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_use   (src_bus),
      .src_ent   (src_ent),
      .src_need  (src_need),
      .dst_use   (dst_bus),
      .dst_ent   (dst_ent),
      .dst_need  (dst_need),
      .add_en    (add_b[b]),
      .rel_en    (rel_b[b]),
      .can_place (can_b[b])
    );
  end

  dst_table #(.NDST(NDST), .SRCW(SRCW), .DW(DW)) u_dst (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx      (dst_idx),
    .rd_hit   (dt_hit),
    .rd_bank  (dt_bank),
    .rd_src   (dt_src),
    .set_en   (set_en),
    .set_bank (add_b[1]),
    .set_src  (src_key),
    .clr_en   (clr_en)
  );

  always_comb begin
    add_b  = 2'b00;
    rel_b  = 2'b00;
    clr_en = 1'b0;
    ok_d   = 1'b0;
    bank_d = 1'b0;
    err_d  = ERR_NONE;
    if (mk) begin
      if (dt_hit) begin
        err_d = ERR_DST_BUSY;
      end else if (can_b[0]) begin
        add_b[0] = 1'b1;
        ok_d     = 1'b1;
      end else if (can_b[1]) begin
        add_b[1] = 1'b1;
        ok_d     = 1'b1;
        bank_d   = 1'b1;
      end else begin
        err_d = ERR_BLOCKED;
      end
    end else if (bk) begin
      if (!dt_hit || (dt_src != src_key)) begin
        err_d = ERR_NO_CONN;
      end else begin
        rel_b[dt_bank] = 1'b1;
        clr_en         = 1'b1;
        ok_d           = 1'b1;
        bank_d         = dt_bank;
      end
    end
    set_en = add_b[0] | add_b[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_bank  <= 1'b0;
      rsp_err   <= 2'd0;
    end else begin
      rsp_valid <= cmd_valid;
      if (cmd_valid) begin
        rsp_ok   <= ok_d;
        rsp_bank <= bank_d;
        rsp_err  <= err_d;
      end
    end
  end

  AST_BANK_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (mk && !dt_hit && can_b[0]) |=> (rsp_ok && !rsp_bank)); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !rsp_valid); // R2

  AST_ONE_BANK_ADD: assert property (@(posedge clk) disable iff (!rst_n)
    !(add_b[0] && add_b[1]) && !(rel_b[0] && rel_b[1])); // R4
endmodule

// File: tb/tb_dual_bank_conn_alloc.sv
`timescale 1ns/1ps
module tb_dual_bank_conn_alloc;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_valid, cmd_break;
  logic [3:0] cmd_src_stream, cmd_dst_stream;
  logic [4:0] cmd_src_slot, cmd_dst_slot;
  logic       rsp_valid, rsp_ok, rsp_bank;
  logic [1:0] rsp_err;

  int n_cmp = 0;
  int n_bad = 0;

  typedef struct {
    bit    ok;
    bit    bank;
    int    err;
    string tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  dual_bank_conn_alloc dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_break(cmd_break),
    .cmd_src_stream(cmd_src_stream), .cmd_src_slot(cmd_src_slot),
    .cmd_dst_stream(cmd_dst_stream), .cmd_dst_slot(cmd_dst_slot),
    .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .rsp_bank(rsp_bank), .rsp_err(rsp_err)
  );

  task automatic send(bit brk, int ss, int st, int ds, int dt,
                      bit ok, bit bank, int err, string tag);
    exp_t e;
    @(negedge clk);
    cmd_valid      = 1'b1;
    cmd_break      = brk;
    cmd_src_stream = 4'(ss);
    cmd_src_slot   = 5'(st);
    cmd_dst_stream = 4'(ds);
    cmd_dst_slot   = 5'(dt);
    e.ok = ok; e.bank = bank; e.err = err; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // monitor: compare each response with the oldest expectation
  always @(negedge clk) begin
    if (rst_n === 1'b1 && rsp_valid === 1'b1) begin
      n_cmp++;
      if (q.size() == 0) begin
        n_bad++;
        $display("FAIL R2: unexpected response ok=%0d err=%0d, expected none", rsp_ok, rsp_err);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (rsp_ok !== e.ok || int'(rsp_err) != e.err || (e.ok && rsp_bank !== e.bank)) begin
          n_bad++;
          $display("FAIL %s: got ok=%0d bank=%0d err=%0d, expected ok=%0d bank=%0d err=%0d",
                   e.tag, rsp_ok, rsp_bank, rsp_err, e.ok, e.bank, e.err);
        end
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_break = 1'b0;
    cmd_src_stream = '0; cmd_src_slot = '0; cmd_dst_stream = '0; cmd_dst_slot = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_cmp++;
    if (rsp_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: rsp_valid=%0d during reset, expected 0", rsp_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_cmp++;
    if (rsp_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R2: rsp_valid=%0d with no command, expected 0", rsp_valid);
    end

    send(0, 0, 0, 4, 0, 1, 0, 0, "R1");   // fresh: bank 0, even-input at pair0 slot0
    send(0, 1, 0, 5, 0, 1, 1, 0, "R4");   // odd-input conflicts in bank 0 -> bank 1
    send(0, 5, 4, 1, 0, 1, 0, 0, "R3");   // partner stream as output agrees -> bank 0
    send(0, 2, 0, 4, 0, 0, 0, 2, "R9");   // destination busy
    send(1, 2, 0, 4, 0, 0, 0, 3, "R9");   // busy make left record intact: wrong source
    send(1, 7, 7, 14, 5, 0, 0, 3, "R10"); // never connected
    send(0, 0, 3, 1, 3, 1, 0, 0, "R3");   // same-slot loopback within a pair
    send(0, 0, 4, 0, 4, 0, 0, 1, "R11");  // same entry, opposite needs
    send(0, 4, 1, 5, 1, 1, 0, 0, "R8");   // local to local
    send(1, 5, 4, 1, 0, 1, 0, 0, "R10");
    send(1, 0, 0, 4, 0, 1, 0, 0, "R10");  // original connection still there
    send(0, 1, 0, 6, 0, 1, 0, 0, "R5");   // slot released: now fits bank 0
    send(0, 0, 1, 4, 2, 1, 0, 0, "R5");   // fan-out: count 1
    send(0, 0, 1, 4, 3, 1, 0, 0, "R5");   // count 2
    send(1, 0, 1, 4, 2, 1, 0, 0, "R10");  // count back to 1
    send(0, 1, 1, 5, 2, 1, 1, 0, "R5");   // still held in bank 0 -> bank 1
    send(0, 3, 0, 5, 3, 1, 0, 0, "R3");   // other pair independent; bank0 now 5
    for (int i = 0; i < 123; i++)
      send(0, 8, 0, 9 + i / 32, i % 32, 1, 0, 0, "R6");
    send(0, 8, 1, 13, 0, 1, 1, 0, "R6");  // bank 0 full -> bank 1
    send(0, 0, 0, 13, 1, 0, 0, 1, "R7");  // full + conflict in bank 1
    send(0, 1, 0, 13, 2, 1, 1, 0, "R7");  // matching direction in bank 1
    send(1, 8, 0, 9, 0, 1, 0, 0, "R10");
    send(0, 8, 2, 13, 4, 1, 0, 0, "R6");  // room again in bank 0
    idle();
    repeat (4) @(negedge clk);
    n_cmp++;
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R2: %0d responses missing, expected 0", q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule